// File: doc/BRIEF.md
# Continuous-Phase Fast-FSK Tone Modulator

This block turns a serial bit stream into a continuous-phase fast-FSK waveform, delivered as signed 10-bit samples at a fixed nominal rate of 57.6 kHz. A prescaler divides the master clock down to a sample tick. The prescaler halves its ratio when the master-clock select says the slower of the two crystals is fitted, so the sample rate is the same on either clock. A two-state bit-timing machine derives a 50 % duty bit clock from the sample tick. On each rising edge of that clock it latches the send data and the preamble request.

A 32-bit phase accumulator advances once per sample tick by a step chosen from the latched bit. A one bit (mark) steps at 1200 Hz. A zero bit (space) steps at 1800 Hz at 1200 bit/s and at 2400 Hz at 2400 bit/s. The top 8 accumulator bits address a folded quarter-wave sine table. The accumulator is never cleared while running, so the waveform has no phase jumps at bit boundaries. While a preamble is latched, the block sends alternating bits of its own and ignores the data pin.

The bit-timing machine has two states. `BT_LOW` is the low half of the bit clock and is entered from reset. `BT_HIGH` is the high half. The transition `BT_LOW -> BT_HIGH` (the rising edge, where the inputs are latched) and the transition `BT_HIGH -> BT_LOW` (the falling edge) each fire on the sample tick that ends a half-bit count.

Top module: `ffsk_modulator`

## Requirements
- R1: While `rst` is high at a clock edge, `bit_clk`, `sample_stb` and `sample_out` are all 0, the bit-timing machine is in `BT_LOW`, and the latched bit is 1 (mark). The accumulator starts at 0 when `cos_mode` is 0 and at a quarter cycle (0x4000_0000) when it is 1.
- R2: `sample_stb` pulses for one clock every TICK_DIV master cycles when `mclk_sel` is 1, and every TICK_DIV/2 cycles when it is 0.
- R3: `bit_clk` changes only on a sample tick. It has a 50 % duty cycle and a period of 24 samples when `mclk_sel` and `rate_sel` are both 1 (2400 bit/s). The period is 48 samples in every other case (1200 bit/s); the combination `mclk_sel`=0 with `rate_sel`=1 is unsupported and falls back to 1200 bit/s.
- R4: `tx_data` and `pre_sel` are latched only on the rising edge of `bit_clk`. Changes at any other time have no effect on the output.
- R5: The per-sample accumulator step is floor(f * 2^32 / 57600). f is 1200 Hz for a latched 1, 1800 Hz for a latched 0 at 1200 bit/s, and 2400 Hz for a latched 0 at 2400 bit/s.
- R6: While the latched preamble request is 1, `tx_data` is ignored and the bits sent are 0,1,0,1,... Each new preamble run begins with 0.
- R7: On each strobe, `sample_out` (two's complement) equals 511*sin(2*pi*(p+0.5)/256) within 2 LSB. Here p is the accumulator's top 8 bits before that tick's step. Bit 7 of p selects the negative half and bit 6 selects the mirrored quarter.
- R8: The accumulator changes only on a sample tick and is never reset outside `rst`. A bit latched on a rising edge first sets the step on the following tick.
- R9: `cos_mode` is used only while `rst` is high. Changing it afterwards has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk_sel | input | 1 | 1: fast master clock (full divider), 0: half-frequency master clock |
| rate_sel | input | 1 | 1: 2400 bit/s (fast clock only), 0: 1200 bit/s |
| cos_mode | input | 1 | Starting phase: 0 sine (0 deg), 1 cosine (90 deg); taken during reset |
| pre_sel | input | 1 | Preamble request, latched on the bit clock rise |
| tx_data | input | 1 | Serial send data, latched on the bit clock rise |
| bit_clk | output | 1 | Transmit bit clock |
| sample_stb | output | 1 | One-cycle strobe marking a new sample |
| sample_out | output | 10 | Signed waveform sample |

## Verification
Assertions check on every cycle that:
- the sample strobe is isolated;
- the bit clock and the accumulator move only on ticks;
- every accumulator step is one of the three legal tone steps;
- the latched bit changes only at a bit clock rise;
- consecutive preamble bits alternate;
- the output is zero when reset lifts.

Only the bench scenarios can show the rest: the exact tick and bit periods for each clock and rate pair, and the true shape of the waveform, compared sample by sample against an arithmetic sine model. They also show that data glitches between rising edges and late changes of the phase mode leave the stream untouched.

// File: rtl/ffsk_pkg.sv
package ffsk_pkg;

    typedef enum logic [0:0] {
        BT_LOW  = 1'b0,
        BT_HIGH = 1'b1
    } bt_state_e;

    // Per-sample phase step for a tone of hz at sample rate fs, acc_w-bit wheel.
    function automatic longint unsigned phase_step(longint unsigned hz,
                                                   longint unsigned fs,
                                                   int acc_w);
        return (hz << acc_w) / fs;
    endfunction

    // Quarter-wave magnitude at half-offset point idx, rational sine approximation.
    function automatic int quarter_mag(int idx, int qbits, int amp);
        longint p;
        longint u;
        longint w;
        p = 4 * (longint'(1) << qbits);
        u = 2 * longint'(idx) + 1;
        w = u * (p - u);
        return int'((longint'(amp) * 4 * w) / ((5 * p * p) / 4 - w));
    endfunction

endpackage

// File: rtl/ffsk_tick_gen.sv
module ffsk_tick_gen #(
    parameter int DIV_MAX = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic mclk_sel,
    output logic tick
);
    localparam int CW = $clog2(DIV_MAX);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim  = mclk_sel ? CW'(DIV_MAX - 1) : CW'(DIV_MAX / 2 - 1);
    assign tick = !rst && (cnt >= lim);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt >= lim)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // R2: a tick never lasts more than one master cycle
    a_r2_tick_isolated: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/ffsk_bit_timer.sv
module ffsk_bit_timer
    import ffsk_pkg::*;
#(
    parameter int HALF_SLOW = 24,
    parameter int HALF_FAST = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic fast,
    input  logic tx_data,
    input  logic pre_sel,
    output logic bit_clk,
    output logic cur_bit
);
    localparam int CW = $clog2(HALF_SLOW);

    bt_state_e     state, nstate;
    logic [CW-1:0] hcnt;
    logic [CW-1:0] half_lim;
    logic          wrap;
    logic          pre_q;
    logic          alt_q;

    assign half_lim = fast ? CW'(HALF_FAST - 1) : CW'(HALF_SLOW - 1);
    assign wrap     = tick && (hcnt == half_lim);

    always_comb begin
        nstate = state;
        unique case (state)
            BT_LOW:  if (wrap) nstate = BT_HIGH;
            BT_HIGH: if (wrap) nstate = BT_LOW;
            default: nstate = BT_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= BT_LOW;
        else
            state <= nstate;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt    <= '0;
            cur_bit <= 1'b1;
            pre_q   <= 1'b0;
            alt_q   <= 1'b0;
        end else if (tick) begin
            hcnt <= wrap ? '0 : hcnt + 1'b1;
            if (state == BT_LOW && wrap) begin
                pre_q <= pre_sel;
                if (pre_sel) begin
                    cur_bit <= alt_q;
                    alt_q   <= ~alt_q;
                end else begin
                    cur_bit <= tx_data;
                    alt_q   <= 1'b0;
                end
            end
        end
    end

    assign bit_clk = (state == BT_HIGH);

    // R3: the bit clock moves only on a sample tick
    a_r3_clk_on_tick: assert property (@(posedge clk) disable iff (rst)
        !$past(tick) |-> $stable(bit_clk));

    // R4: the latched bit changes only at a rising bit clock
    a_r4_bit_holds: assert property (@(posedge clk) disable iff (rst)
        !$rose(bit_clk) |-> $stable(cur_bit));

    // R6: back-to-back preamble bits alternate
    a_r6_preamble_alt: assert property (@(posedge clk) disable iff (rst)
        ($rose(bit_clk) && pre_q && $past(pre_q)) |-> (cur_bit != $past(cur_bit)));

endmodule

// File: rtl/ffsk_nco.sv
module ffsk_nco
    import ffsk_pkg::*;
#(
    parameter int ACC_W         = 32,
    parameter int ADDR_W        = 8,
    parameter int OUT_W         = 10,
    parameter int SAMPLE_HZ     = 57600,
    parameter int MARK_HZ       = 1200,
    parameter int SPACE_SLOW_HZ = 1800,
    parameter int SPACE_FAST_HZ = 2400
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick,
    input  logic                    fast,
    input  logic                    cur_bit,
    input  logic                    cos_mode,
    output logic signed [OUT_W-1:0] sample_out,
    output logic                    sample_stb
);
    localparam int QB  = ADDR_W - 2;
    localparam int QN  = 1 << QB;
    localparam int AMP = (1 << (OUT_W - 1)) - 1;
    localparam logic [ACC_W-1:0] INC_MARK = ACC_W'(phase_step(MARK_HZ, SAMPLE_HZ, ACC_W));
    localparam logic [ACC_W-1:0] INC_SS   = ACC_W'(phase_step(SPACE_SLOW_HZ, SAMPLE_HZ, ACC_W));
    localparam logic [ACC_W-1:0] INC_SF   = ACC_W'(phase_step(SPACE_FAST_HZ, SAMPLE_HZ, ACC_W));
    localparam logic [ACC_W-1:0] ACC_QTR  = {2'b01, {(ACC_W-2){1'b0}}};

    logic [OUT_W-2:0]        qtab [QN];
    logic [ACC_W-1:0]        acc;
    logic [ACC_W-1:0]        step;
    logic [ADDR_W-1:0]       p;
    logic [QB-1:0]           idx;
    logic signed [OUT_W-1:0] mag_s;
    logic signed [OUT_W-1:0] val;

    for (genvar g = 0; g < QN; g++) begin : g_qtab
        assign qtab[g] = (OUT_W-1)'(quarter_mag(g, QB, AMP));
    end

    assign step  = cur_bit ? INC_MARK : (fast ? INC_SF : INC_SS);
    assign p     = acc[ACC_W-1 -: ADDR_W];
    assign idx   = p[ADDR_W-2] ? ~p[QB-1:0] : p[QB-1:0];
    assign mag_s = {1'b0, qtab[idx]};
    assign val   = p[ADDR_W-1] ? -mag_s : mag_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc        <= cos_mode ? ACC_QTR : '0;
            sample_out <= '0;
            sample_stb <= 1'b0;
        end else begin
            sample_stb <= tick;
            if (tick) begin
                acc        <= acc + step;
                sample_out <= val;
            end
        end
    end

    // R8: the accumulator only advances on a tick
    a_r8_acc_on_tick: assert property (@(posedge clk) disable iff (rst)
        !$past(tick) |-> $stable(acc));

    // R5: every advance is one of the three tone steps
    a_r5_step_legal: assert property (@(posedge clk) disable iff (rst)
        $past(tick) |-> ((acc - $past(acc)) == INC_MARK ||
                         (acc - $past(acc)) == INC_SS ||
                         (acc - $past(acc)) == INC_SF));

    // R1: output at mid-scale zero right after reset
    a_r1_zero_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (sample_out == '0 && !sample_stb));

    // R2: strobe is a single-cycle pulse
    a_r2_stb_pulse: assert property (@(posedge clk) disable iff (rst)
        sample_stb |=> !sample_stb);

endmodule

// File: rtl/ffsk_modulator.sv
module ffsk_modulator #(
    parameter int TICK_DIV      = 128,
    parameter int SAMPLE_HZ     = 57600,
    parameter int RATE_SLOW_BPS = 1200,
    parameter int RATE_FAST_BPS = 2400,
    parameter int MARK_HZ       = 1200,
    parameter int SPACE_SLOW_HZ = 1800,
    parameter int SPACE_FAST_HZ = 2400,
    parameter int ACC_W         = 32,
    parameter int ADDR_W        = 8,
    parameter int OUT_W         = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mclk_sel,
    input  logic                    rate_sel,
    input  logic                    cos_mode,
    input  logic                    pre_sel,
    input  logic                    tx_data,
    output logic                    bit_clk,
    output logic                    sample_stb,
    output logic signed [OUT_W-1:0] sample_out
);
    localparam int HALF_SLOW = SAMPLE_HZ / (2 * RATE_SLOW_BPS);
    localparam int HALF_FAST = SAMPLE_HZ / (2 * RATE_FAST_BPS);

    logic tick;
    logic fast;
    logic cur_bit;

    // the unsupported slow-clock / fast-rate pair falls back to the slow rate
    assign fast = mclk_sel & rate_sel;

    ffsk_tick_gen #(
        .DIV_MAX(TICK_DIV)
    ) u_tick (
        .clk      (clk),
        .rst      (rst),
        .mclk_sel (mclk_sel),
        .tick     (tick)
    );

    ffsk_bit_timer #(
        .HALF_SLOW(HALF_SLOW),
        .HALF_FAST(HALF_FAST)
    ) u_bits (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .fast    (fast),
        .tx_data (tx_data),
        .pre_sel (pre_sel),
        .bit_clk (bit_clk),
        .cur_bit (cur_bit)
    );

    ffsk_nco #(
        .ACC_W         (ACC_W),
        .ADDR_W        (ADDR_W),
        .OUT_W         (OUT_W),
        .SAMPLE_HZ     (SAMPLE_HZ),
        .MARK_HZ       (MARK_HZ),
        .SPACE_SLOW_HZ (SPACE_SLOW_HZ),
        .SPACE_FAST_HZ (SPACE_FAST_HZ)
    ) u_nco (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .fast       (fast),
        .cur_bit    (cur_bit),
        .cos_mode   (cos_mode),
        .sample_out (sample_out),
        .sample_stb (sample_stb)
    );

endmodule

// File: tb/ffsk_modulator_tb.sv
module ffsk_modulator_tb;

    localparam int  DIV = 4;
    localparam int  SFS = 57600;
    localparam real PI  = 3.14159265358979;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst = 1'b1;
    logic mclk_sel = 1'b1, rate_sel = 1'b0, cos_mode = 1'b0;
    logic pre_sel = 1'b0, tx_data = 1'b0;
    logic bit_clk, sample_stb;
    logic signed [9:0] sample_out;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 0;

    ffsk_modulator #(.TICK_DIV(DIV)) u_dut (
        .clk(clk), .rst(rst), .mclk_sel(mclk_sel), .rate_sel(rate_sel),
        .cos_mode(cos_mode), .pre_sel(pre_sel), .tx_data(tx_data),
        .bit_clk(bit_clk), .sample_stb(sample_stb), .sample_out(sample_out)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R5: step = floor(f * 2^32 / fs)
    function automatic logic [31:0] inc_of(bit b, bit fast);
        longint unsigned hz;
        hz = b ? 1200 : (fast ? 2400 : 1800);
        return 32'((hz << 32) / SFS);
    endfunction

    // R7: ideal sample for the top 8 accumulator bits
    function automatic real tab_exp(logic [31:0] a);
        return 511.0 * $sin(2.0 * PI * (real'(int'(a[31:24])) + 0.5) / 256.0);
    endfunction

    task automatic run(input bit mcs, input bit brs, input bit cosm, input int nbits);
        int          div;
        bit          fast;
        int          spb;
        int          cyc;
        int          last_stb;
        int          last_rise;
        int          rises;
        int          glitch;
        bit          prev_bc;
        bit          drv_d, drv_p, bit_m, alt_m;
        logic [31:0] acc_m;
        logic [15:0] lf;
        real         e, d;
        div  = mcs ? DIV : DIV / 2;
        fast = mcs && brs;
        spb  = fast ? 24 : 48;
        rst = 1'b1; mclk_sel = mcs; rate_sel = brs; cos_mode = cosm;
        pre_sel = 1'b0; tx_data = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(bit_clk == 1'b0, "R1 bit_clk in reset", longint'(bit_clk), 0);
        chk(sample_out == 10'sd0, "R1 sample in reset", longint'(sample_out), 0);
        chk(sample_stb == 1'b0, "R1 strobe in reset", longint'(sample_stb), 0);
        rst = 1'b0;
        cos_mode = ~cosm;          // R9: must have no effect now
        acc_m = cosm ? 32'h4000_0000 : 32'h0;
        bit_m = 1'b1; alt_m = 1'b0;
        drv_d = 1'b0; drv_p = 1'b0;
        lf = 16'hACE1 ^ {13'd0, mcs, brs, cosm};
        cyc = 0; last_stb = -1; last_rise = -1; rises = 0; glitch = 0; prev_bc = 1'b0;
        while (rises < nbits) begin
            @(negedge clk);
            cyc++;
            if (glitch > 0) begin
                glitch--;
                if (glitch == 0) tx_data = drv_d;
            end
            if (sample_stb) begin
                if (last_stb >= 0)
                    chk(cyc - last_stb == div, "R2 strobe spacing", cyc - last_stb, div);
                last_stb = cyc;
                e = tab_exp(acc_m);
                d = real'(int'(sample_out)) - e;
                // R7 shape, R5 steps, R8 continuity, R4/R9 ignored stimulus
                chk(d <= 2.0 && d >= -2.0, alt_m || drv_p ? "R6 R7 sample" : "R7 R5 R8 sample",
                    longint'(sample_out), longint'($rtoi(e)));
                acc_m = acc_m + inc_of(bit_m, fast);
            end
            if (bit_clk && !prev_bc) begin
                chk(sample_stb, "R3 rise on tick", longint'(sample_stb), 1);
                if (last_rise >= 0)
                    chk(cyc - last_rise == spb * div, "R3 bit period", cyc - last_rise, spb * div);
                last_rise = cyc;
                rises++;
                if (drv_p) begin bit_m = alt_m; alt_m = ~alt_m; end
                else begin bit_m = drv_d; alt_m = 1'b0; end
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                drv_d = lf[0];
                drv_p = ((rises % 16) >= 6) && ((rises % 16) < 11);   // R6 preamble run
                pre_sel = drv_p;
                tx_data = drv_d;
                glitch = 0;
            end
            if (!bit_clk && prev_bc) begin
                chk(cyc - last_rise == (spb / 2) * div, "R3 duty", cyc - last_rise, (spb / 2) * div);
                tx_data = ~drv_d;  // R4: mid-bit glitch must be ignored
                glitch = 3;
            end
            prev_bc = bit_clk;
        end
    endtask

    initial begin
        for (int m = 0; m < 2; m++)
            for (int r = 0; r < 2; r++)
                for (int c = 0; c < 2; c++)
                    run(m[0], r[0], c[0], 20);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL R3 watchdog actual=timeout expected=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule